// File: doc/BRIEF.md
# Transmit Doubleword Pairing and Padding Buffer

This block sits between user logic and a 64-bit transmit link. User logic offers a stream of 32-bit doublewords on a valid/ready interface. Each packet begins with its command, which is one or two doublewords long, and continues with zero or more data doublewords. The block packs this stream into 64-bit beats. Each beat carries one control flag per doubleword. The flag is 1 for command and fill doublewords and 0 for data doublewords.

Two kinds of fill doubleword (a constant NOP value) keep command and data apart. A short command is topped up with a NOP in its upper half. A payload with an odd number of doublewords is closed by a NOP in the upper half of its last beat. As a result, every command starts in the lower doubleword of a fresh beat.

Back-pressure works as follows. A beat sits in the output register, with `out_valid` high, until `out_ready` is seen high at a clock edge. While that beat is held, `in_ready` stays low, so no doubleword is lost or reordered. When the output register is empty, or is being drained in the same cycle, `in_ready` is high. An input doubleword is taken on any edge where both `in_valid` and `in_ready` are high.

Top module: `tx_align_buf`

## Requirements
- R1: A synchronous active-high `rst` empties the output register and drops any half-assembled beat or packet state. After reset, `out_valid` is 0, `in_ready` is 1, and the next doubleword taken is treated as a command.
- R2: A command doubleword with bit 31 clear is a short command. Bits 3:0 of the first command doubleword give the number of data doublewords that follow the command. For a short command, the block emits the command in bits 31:0 and the NOP value in bits 63:32, with `out_ctl` = 2'b11.
- R3: A command doubleword with bit 31 set is a long command. Its second doubleword forms bits 63:32 and its first doubleword forms bits 31:0 of one beat, with `out_ctl` = 2'b11 and no fill.
- R4: Data doublewords are paired in arrival order, the earlier one in bits 31:0. Each full data pair is emitted with `out_ctl` = 2'b00.
- R5: When the data count is odd, the last data doubleword is emitted in bits 31:0 with the NOP value in bits 63:32 and `out_ctl` = 2'b10.
- R6: Every command starts in the lower doubleword of a new beat. Bit 0 of `out_ctl` is the lower flag and bit 1 is the upper flag. A beat never carries a command or fill doubleword in the lower half together with data in the upper half, so `out_ctl` = 2'b01 never appears.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_ctl` stay unchanged and `in_ready` is 0.
- R8: Every accepted doubleword appears exactly once at the output, in order. The number of beats equals the sum over packets of one command beat plus the data doublewords divided by two, rounded up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input doubleword offered |
| in_ready | output | 1 | Block can take a doubleword this cycle |
| in_dw | input | 32 | Input doubleword |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Link takes the beat this cycle |
| out_data | output | 64 | Output beat, lower doubleword in bits 31:0 |
| out_ctl | output | 2 | Per-doubleword control flags, bit 0 for the lower doubleword |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the output beat holds steady under stall and input is blocked while it waits (R7);
- the forbidden flag pair 2'b01 never appears (R6);
- every 2'b10 beat carries the NOP value in its upper half (R5);
- reset empties the output (R1).

Other behaviours only the bench scenarios can show:
- correct placement of short and long commands;
- pairing of even and odd payloads in arrival order;
- a command following an odd payload starting in a fresh lower doubleword;
- the total beat count;
- a reset in the middle of a long command discarding the half-built beat.

// File: rtl/tx_align_pkg.sv
package tx_align_pkg;
  typedef enum logic [1:0] {
    PH_CMD_LO = 2'd0,
    PH_CMD_HI = 2'd1,
    PH_DATA   = 2'd2
  } phase_e;
endpackage

// File: rtl/tx_align_parser.sv
// Tracks packet phase; tags each accepted doubleword with its control flag
// and whether it closes a segment (command or payload).
module tx_align_parser
  import tx_align_pkg::*;
#(
  parameter int DW_W     = 32,
  parameter int CNT_W    = 4,
  parameter int CNT_LSB  = 0,
  parameter int LONG_BIT = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [DW_W-1:0] dw,
  output logic            tok_ctl,
  output logic            tok_close
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] cnt_field;
  logic             long_cmd;

  assign cnt_field = dw[CNT_LSB +: CNT_W];
  assign long_cmd  = dw[LONG_BIT];

  always_comb begin
    phase_d   = phase_q;
    rem_d     = rem_q;
    tok_ctl   = 1'b1;
    tok_close = 1'b0;
    unique case (phase_q)
      PH_CMD_LO: begin
        tok_close = !long_cmd;
        rem_d     = cnt_field;
        if (long_cmd)               phase_d = PH_CMD_HI;
        else if (cnt_field != '0)   phase_d = PH_DATA;
      end
      PH_CMD_HI: begin
        tok_close = 1'b1;
        phase_d   = (rem_q != '0) ? PH_DATA : PH_CMD_LO;
      end
      PH_DATA: begin
        tok_ctl   = 1'b0;
        tok_close = (rem_q == CNT_W'(1));
        rem_d     = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) phase_d = PH_CMD_LO;
      end
      default: phase_d = PH_CMD_LO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CMD_LO;
      rem_q   <= '0;
    end else if (take) begin
      phase_q <= phase_d;
      rem_q   <= rem_d;
    end
  end
endmodule

// File: rtl/tx_align_pairer.sv
// Packs tagged doublewords into two-doubleword beats, inserting fill when a
// segment closes in the lower half; one-entry output register with handshake.
module tx_align_pairer #(
  parameter int              DW_W   = 32,
  parameter logic [DW_W-1:0] NOP_DW = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW_W-1:0]   dw,
  input  logic              tok_ctl,
  input  logic              tok_close,
  output logic              in_ready,
  output logic              take,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [2*DW_W-1:0] out_data,
  output logic [1:0]        out_ctl
);
  logic            lo_full_q;
  logic [DW_W-1:0] lo_dw_q;
  logic            lo_ctl_q;
  logic            emit;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign emit     = take && (lo_full_q || tok_close);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_full_q <= 1'b0;
      lo_dw_q   <= '0;
      lo_ctl_q  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctl   <= '0;
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        if (lo_full_q) begin
          out_data  <= {dw, lo_dw_q};
          out_ctl   <= {tok_ctl, lo_ctl_q};
          lo_full_q <= 1'b0;
        end else begin
          out_data <= {NOP_DW, dw};
          out_ctl  <= {1'b1, tok_ctl};
        end
      end else begin
        if (out_ready) out_valid <= 1'b0;
        if (take) begin
          lo_dw_q   <= dw;
          lo_ctl_q  <= tok_ctl;
          lo_full_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tx_align_buf.sv
module tx_align_buf #(
  parameter int                DW_W     = 32,
  parameter int                CNT_W    = 4,
  parameter int                CNT_LSB  = 0,
  parameter int                LONG_BIT = 31,
  parameter logic [DW_W-1:0]   NOP_DW   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW_W-1:0]   in_dw,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*DW_W-1:0] out_data,
  output logic [1:0]        out_ctl
);
  logic take, tok_ctl, tok_close;

  tx_align_parser #(
    .DW_W(DW_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB), .LONG_BIT(LONG_BIT)
  ) parser_i (
    .clk(clk), .rst(rst), .take(take), .dw(in_dw),
    .tok_ctl(tok_ctl), .tok_close(tok_close)
  );

  tx_align_pairer #(.DW_W(DW_W), .NOP_DW(NOP_DW)) pairer_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dw(in_dw),
    .tok_ctl(tok_ctl), .tok_close(tok_close), .in_ready(in_ready),
    .take(take), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ctl(out_ctl)
  );
endmodule

// File: rtl/tx_align_buf_chk.sv
module tx_align_buf_chk #(
  parameter int              DW_W   = 32,
  parameter logic [DW_W-1:0] NOP_DW = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*DW_W-1:0] out_data,
  input logic [1:0]        out_ctl
);
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ctl));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_no_data_after_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_ctl != 2'b01);

  p_odd_fill_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ctl == 2'b10 |-> out_data[2*DW_W-1:DW_W] == NOP_DW);
endmodule

bind tx_align_buf tx_align_buf_chk #(.DW_W(DW_W), .NOP_DW(NOP_DW)) chk_i (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_ctl(out_ctl)
);

// File: tb/tx_align_buf_tb_top.sv
module tx_align_buf_tb_top;
  localparam int N_IN  = 17;
  localparam int N_OUT = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dw = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [1:0]  out_ctl;

  int checks = 0;
  int fails  = 0;
  int beat   = 0;
  bit mon_en = 1'b0;

  always #5 clk = ~clk;

  tx_align_buf dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dw(in_dw), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctl(out_ctl)
  );

  // Input stream: short, long, even, odd, long+odd, long+even packets.
  localparam logic [31:0] IN_VEC [N_IN] = '{
    32'h0000_0A00,
    32'h8000_0B00, 32'h1111_2222,
    32'h0000_0C02, 32'hD000_0001, 32'hD000_0002,
    32'h0000_0D03, 32'hE000_0001, 32'hE000_0002, 32'hE000_0003,
    32'h8000_0E01, 32'h3333_4444, 32'hF000_0001,
    32'h8000_0F02, 32'h5555_6666, 32'h7777_7777, 32'h8888_8888
  };
  // Expected beats: {ctl, data}
  localparam logic [65:0] OUT_VEC [N_OUT] = '{
    {2'b11, 32'h0,         32'h0000_0A00},
    {2'b11, 32'h1111_2222, 32'h8000_0B00},
    {2'b11, 32'h0,         32'h0000_0C02},
    {2'b00, 32'hD000_0002, 32'hD000_0001},
    {2'b11, 32'h0,         32'h0000_0D03},
    {2'b00, 32'hE000_0002, 32'hE000_0001},
    {2'b10, 32'h0,         32'hE000_0003},
    {2'b11, 32'h3333_4444, 32'h8000_0E01},
    {2'b10, 32'h0,         32'hF000_0001},
    {2'b11, 32'h5555_6666, 32'h8000_0F02},
    {2'b00, 32'h8888_8888, 32'h7777_7777}
  };

  task automatic check(input bit ok, input string req, input logic [65:0] act,
                       input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] c);
    if (c == 2'b11) return "R2/R3/R6";
    if (c == 2'b10) return "R5";
    return "R4";
  endfunction

  // Table monitor: one beat per negedge with valid and ready.
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      if (beat < N_OUT)
        check({out_ctl, out_data} == OUT_VEC[beat], tag_of(OUT_VEC[beat][65:64]),
              {out_ctl, out_data}, OUT_VEC[beat]);
      else
        check(1'b0, "R8 extra beat", {out_ctl, out_data}, '0);
      beat++;
    end
  end

  task automatic send(input logic [31:0] d);
    in_valid = 1'b1;
    in_dw    = d;
    do @(posedge clk); while (!in_ready);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    logic [65:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", {65'b0, out_valid}, 66'd0);
    check(in_ready == 1'b1, "R1 in_ready", {65'b0, in_ready}, 66'd1);

    @(posedge clk); #1;
    mon_en = 1'b1;
    for (int i = 0; i < N_IN; i++) send(IN_VEC[i]);
    repeat (4) @(posedge clk);
    #1 mon_en = 1'b0;
    check(beat == N_OUT, "R8 beat count", 66'(beat), 66'(N_OUT));

    // R7: stall with a short command held in the output register
    out_ready = 1'b0;
    send(32'h0000_0100);
    @(negedge clk);
    held = {2'b11, 32'h0, 32'h0000_0100};
    check(out_valid && {out_ctl, out_data} == held, "R7 beat loaded", {out_ctl, out_data}, held);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && {out_ctl, out_data} == held, "R7 hold", {out_ctl, out_data}, held);
      check(in_ready == 1'b0, "R7 in_ready low", {65'b0, in_ready}, 66'd0);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", {65'b0, out_valid}, 66'd0);

    // R1: reset in the middle of a long command drops the half beat
    @(posedge clk); #1;
    send(32'h8000_0200);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after mid reset", {65'b0, out_valid}, 66'd0);
    @(posedge clk); #1;
    send(32'h0000_0300);
    @(negedge clk);
    held = {2'b11, 32'h0, 32'h0000_0300};
    check(out_valid && {out_ctl, out_data} == held, "R1 fresh command", {out_ctl, out_data}, held);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule